// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

The walker drives the descriptor side of a card host DMA engine. Software places a chain of 64-bit descriptors in memory, sets the expected byte total for the transfer and pulses `start_i` with the address of the first descriptor. The walker reads one descriptor at a time over a request/response memory port and decodes its attribute bits. Transfer entries become one address/length command to a data mover. Link entries redirect the walk to a new descriptor address. No-op and reserved entries are stepped over. The walk ends at the first entry that carries the end flag, or at the first fault.

Each 64-bit descriptor holds a 32-bit address in bits 63:32 and a 16-bit byte length in bits 31:16. Bit 5 and bit 4 form the activity pair (act_hi, act_lo). Bit 2 requests an interrupt, bit 1 marks the last entry and bit 0 marks the entry valid. Bits 15:6 and bit 3 are reserved and must be zero. On a fault the walker raises either a descriptor-fault flag or a byte-total-mismatch flag. With it, it records a 2-bit phase code: 0 stopped, 1 fetching, 2 changing address, 3 moving data.

Both the memory request and the memory response use valid/ready handshakes, and so does the mover command. Once a valid is raised, it and its payload stay unchanged until ready is seen high at a clock edge. The walker keeps at most one memory read in flight. It keeps at most one mover command in flight, and that command is closed by a one-cycle `mv_done_i` pulse.

Top module: `sg_desc_walker`

## Requirements
- R1: A fetched descriptor with bit 0 clear, or with any of bits 15:6 or bit 3 set, sets `desc_err_o`, sets `err_state_o` to 1 and ends the walk with no `done_o` pulse and no further reads.
- R2: Activity 00 (no-op) and 01 (reserved) issue no mover command, and the next descriptor is fetched from the current descriptor address plus 8.
- R3: Activity 10 issues exactly one mover command, with `mv_addr_o` set to bits 63:32 and `mv_len_o` set to bits 31:16. The next descriptor is not fetched until `mv_done_i` has been seen. A zero length issues no command.
- R4: Activity 11 makes bits 63:32 the next descriptor address. A link address whose bits 2:0 are not zero sets `desc_err_o` with `err_state_o` equal to 2, unless the entry also carries the end flag.
- R5: An entry with bit 1 set is the last one processed, and a link entry marked this way is not followed. If the issued byte total equals the expected total, `done_o` pulses for one cycle as `busy_o` falls.
- R6: Every entry that is fully processed with bit 2 set gives one single-cycle `irq_o` pulse. This includes the last entry. An entry that faults gives none.
- R7: A transfer entry whose address or length is not a multiple of 4 sets `desc_err_o` with `err_state_o` equal to 1 and issues no command.
- R8: When the last entry is reached and the sum of issued lengths differs from `expect_bytes_i` (sampled at start), `len_err_o` is set and `err_state_o` is 0. No `done_o` pulse is given.
- R9: Request and command valids hold, with stable payload, until accepted. Exactly one memory read is issued per descriptor visited.
- R10: After reset, and while idle, all flags and valids are low. A start clears both error flags. A start pulse while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk (used only while idle) |
| start_addr_i | input | 32 | Address of the first descriptor |
| expect_bytes_i | input | TOT_W | Expected byte total for the walk |
| rd_req_valid_o | output | 1 | Descriptor read request valid |
| rd_req_ready_i | input | 1 | Memory accepts the request |
| rd_req_addr_o | output | 32 | Descriptor read address |
| rd_rsp_valid_i | input | 1 | Descriptor data valid |
| rd_rsp_ready_o | output | 1 | Walker accepts descriptor data |
| rd_rsp_data_i | input | 64 | Descriptor word |
| mv_valid_o | output | 1 | Mover command valid |
| mv_ready_i | input | 1 | Mover accepts the command |
| mv_addr_o | output | 32 | Data address for the mover |
| mv_len_o | output | 16 | Byte count for the mover |
| mv_done_i | input | 1 | Mover finished the accepted command |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| irq_o | output | 1 | One-cycle descriptor interrupt pulse |
| desc_err_o | output | 1 | Descriptor fault flag (held until next start) |
| len_err_o | output | 1 | Byte total mismatch flag (held until next start) |
| err_state_o | output | 2 | Phase code captured at the fault |

## Verification
A wrong next-address computation appears at once on `rd_req_addr_o` for the following fetch. Often it also appears a few cycles later as a descriptor fault, because the bench leaves unused memory zeroed and so marked invalid. A wrong decode shows up as missing, extra or altered mover commands before the walk ends. Faults in the byte tally or in the phase code stay hidden until the final entry, where they change `done_o`, `len_err_o` or `err_state_o` in the cycle `busy_o` drops.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int DESC_W   = 64;
  localparam int PTR_W    = 32;
  localparam int LEN_W    = 16;
  localparam int STRIDE   = 8;

  typedef enum logic [2:0] {
    W_IDLE, W_RQ, W_RSP, W_DEC, W_CMD, W_WAIT, W_ENTRY
  } walk_st_t;

  typedef enum logic [1:0] {
    ACT_NOP  = 2'b00,
    ACT_SKIP = 2'b01,
    ACT_XFER = 2'b10,
    ACT_LINK = 2'b11
  } act_t;

  localparam logic [1:0] PH_STOP  = 2'd0;
  localparam logic [1:0] PH_FETCH = 2'd1;
  localparam logic [1:0] PH_ADDR  = 2'd2;
  localparam logic [1:0] PH_MOVE  = 2'd3;

  typedef struct packed {
    logic [PTR_W-1:0] addr;
    logic [LEN_W-1:0] len;
    act_t             act;
    logic             intr;
    logic             last;
    logic             ok;        // valid and reserved bits clear
    logic             xfer_bad;  // misaligned transfer
    logic             link_bad;  // misaligned link target
  } desc_info_t;
endpackage

// File: rtl/sgw_desc_decode.sv
module sgw_desc_decode
  import sgw_pkg::*;
(
  input  logic [DESC_W-1:0] raw_i,
  output desc_info_t        info_o
);
  logic rsvd_nz;

  always_comb begin
    rsvd_nz         = (|raw_i[15:6]) | raw_i[3];
    info_o.addr     = raw_i[63:32];
    info_o.len      = raw_i[31:16];
    info_o.act      = act_t'(raw_i[5:4]);
    info_o.intr     = raw_i[2];
    info_o.last     = raw_i[1];
    info_o.ok       = raw_i[0] & ~rsvd_nz;
    info_o.xfer_bad = (|raw_i[33:32]) | (|raw_i[17:16]);
    info_o.link_bad = |raw_i[34:32];
  end
endmodule

// File: rtl/sgw_byte_tally.sv
module sgw_byte_tally
  import sgw_pkg::*;
#(
  parameter int TOT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [TOT_W-1:0] exp_i,
  input  logic             add_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             mismatch_o
);
  localparam int SUM_W = TOT_W + 1;

  logic [TOT_W-1:0] total_q, exp_q;
  logic             over_q;
  logic [SUM_W-1:0] sum;

  assign sum = {1'b0, total_q} + SUM_W'(len_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
      exp_q   <= '0;
      over_q  <= 1'b0;
    end else if (clr_i) begin
      total_q <= '0;
      exp_q   <= exp_i;
      over_q  <= 1'b0;
    end else if (add_i) begin
      total_q <= sum[TOT_W-1:0];
      if (sum[TOT_W]) over_q <= 1'b1;
    end
  end

  assign mismatch_o = over_q | (total_q != exp_q);

  AST_ADD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    add_i |-> (len_i != '0)) else $error("zero-length add"); // R3
endmodule

// File: rtl/sgw_walk_ctrl.sv
module sgw_walk_ctrl
  import sgw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PTR_W-1:0]  start_addr_i,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [PTR_W-1:0]  rd_req_addr_o,
  input  logic              rd_rsp_valid_i,
  output logic              rd_rsp_ready_o,
  input  logic [DESC_W-1:0] rd_rsp_data_i,
  output logic              mv_valid_o,
  input  logic              mv_ready_i,
  output logic [PTR_W-1:0]  mv_addr_o,
  output logic [LEN_W-1:0]  mv_len_o,
  input  logic              mv_done_i,
  output logic [DESC_W-1:0] desc_o,
  input  desc_info_t        info_i,
  output logic              tally_clr_o,
  output logic              tally_add_o,
  input  logic              mismatch_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o,
  output logic              desc_err_o,
  output logic              len_err_o,
  output logic [1:0]        err_state_o
);
  walk_st_t          st_q;
  logic [PTR_W-1:0]  cur_q;
  logic [DESC_W-1:0] desc_q;
  logic              done_q, irq_q, derr_q, lerr_q;
  logic [1:0]        ph_q;
  logic              go;

  assign go = (st_q == W_IDLE) && start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      cur_q  <= '0;
      desc_q <= '0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      derr_q <= 1'b0;
      lerr_q <= 1'b0;
      ph_q   <= PH_STOP;
    end else begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      unique case (st_q)
        W_IDLE: if (start_i) begin
          cur_q  <= start_addr_i;
          derr_q <= 1'b0;
          lerr_q <= 1'b0;
          ph_q   <= PH_STOP;
          st_q   <= W_RQ;
        end
        W_RQ:  if (rd_req_ready_i) st_q <= W_RSP;
        W_RSP: if (rd_rsp_valid_i) begin
          desc_q <= rd_rsp_data_i;
          st_q   <= W_DEC;
        end
        W_DEC: begin
          if (!info_i.ok) begin
            derr_q <= 1'b1;
            ph_q   <= PH_FETCH;
            st_q   <= W_IDLE;
          end else begin
            unique case (info_i.act)
              ACT_XFER: begin
                if (info_i.xfer_bad) begin
                  derr_q <= 1'b1;
                  ph_q   <= PH_FETCH;
                  st_q   <= W_IDLE;
                end else if (info_i.len == '0) begin
                  st_q <= W_ENTRY;
                end else begin
                  st_q <= W_CMD;
                end
              end
              ACT_LINK: begin
                if (info_i.link_bad && !info_i.last) begin
                  derr_q <= 1'b1;
                  ph_q   <= PH_ADDR;
                  st_q   <= W_IDLE;
                end else begin
                  st_q <= W_ENTRY;
                end
              end
              default: st_q <= W_ENTRY;
            endcase
          end
        end
        W_CMD:  if (mv_ready_i) st_q <= W_WAIT;
        W_WAIT: if (mv_done_i)  st_q <= W_ENTRY;
        W_ENTRY: begin
          irq_q <= info_i.intr;
          if (info_i.last) begin
            if (mismatch_i) begin
              lerr_q <= 1'b1;
              ph_q   <= PH_STOP;
            end else begin
              done_q <= 1'b1;
            end
            st_q <= W_IDLE;
          end else begin
            cur_q <= (info_i.act == ACT_LINK) ? info_i.addr
                                              : cur_q + PTR_W'(STRIDE);
            st_q  <= W_RQ;
          end
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign rd_req_valid_o = (st_q == W_RQ);
  assign rd_req_addr_o  = cur_q;
  assign rd_rsp_ready_o = (st_q == W_RSP);
  assign mv_valid_o     = (st_q == W_CMD);
  assign mv_addr_o      = info_i.addr;
  assign mv_len_o       = info_i.len;
  assign desc_o         = desc_q;
  assign tally_clr_o    = go;
  assign tally_add_o    = (st_q == W_CMD) && mv_ready_i;
  assign busy_o         = (st_q != W_IDLE);
  assign done_o         = done_q;
  assign irq_o          = irq_q;
  assign desc_err_o     = derr_q;
  assign len_err_o      = lerr_q;
  assign err_state_o    = ph_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid_o && !rd_req_ready_i) |=> (rd_req_valid_o && $stable(rd_req_addr_o)))
    else $error("read request dropped"); // R9
  AST_MV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid_o && !mv_ready_i) |=> (mv_valid_o && $stable(mv_addr_o) && $stable(mv_len_o)))
    else $error("mover command dropped"); // R9
  AST_MV_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid_o |-> (mv_addr_o[1:0] == 2'b00 && mv_len_o[1:0] == 2'b00 && mv_len_o != '0))
    else $error("bad mover command"); // R7
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(desc_err_o || len_err_o)) else $error("done with fault"); // R5
  AST_FAULT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(desc_err_o) |-> !busy_o) else $error("walk continued after fault"); // R1
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o) else $error("irq longer than one cycle"); // R6
endmodule

// File: rtl/sg_desc_walker.sv
module sg_desc_walker
  import sgw_pkg::*;
#(
  parameter int TOT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [31:0]       start_addr_i,
  input  logic [TOT_W-1:0]  expect_bytes_i,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [31:0]       rd_req_addr_o,
  input  logic              rd_rsp_valid_i,
  output logic              rd_rsp_ready_o,
  input  logic [63:0]       rd_rsp_data_i,
  output logic              mv_valid_o,
  input  logic              mv_ready_i,
  output logic [31:0]       mv_addr_o,
  output logic [15:0]       mv_len_o,
  input  logic              mv_done_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o,
  output logic              desc_err_o,
  output logic              len_err_o,
  output logic [1:0]        err_state_o
);
  logic [DESC_W-1:0] desc;
  desc_info_t        info;
  logic              t_clr, t_add, t_mis;

  sgw_desc_decode u_dec (
    .raw_i  (desc),
    .info_o (info)
  );

  sgw_byte_tally #(.TOT_W(TOT_W)) u_tally (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (t_clr),
    .exp_i      (expect_bytes_i),
    .add_i      (t_add),
    .len_i      (info.len),
    .mismatch_o (t_mis)
  );

  sgw_walk_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .start_addr_i   (start_addr_i),
    .rd_req_valid_o (rd_req_valid_o),
    .rd_req_ready_i (rd_req_ready_i),
    .rd_req_addr_o  (rd_req_addr_o),
    .rd_rsp_valid_i (rd_rsp_valid_i),
    .rd_rsp_ready_o (rd_rsp_ready_o),
    .rd_rsp_data_i  (rd_rsp_data_i),
    .mv_valid_o     (mv_valid_o),
    .mv_ready_i     (mv_ready_i),
    .mv_addr_o      (mv_addr_o),
    .mv_len_o       (mv_len_o),
    .mv_done_i      (mv_done_i),
    .desc_o         (desc),
    .info_i         (info),
    .tally_clr_o    (t_clr),
    .tally_add_o    (t_add),
    .mismatch_i     (t_mis),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .irq_o          (irq_o),
    .desc_err_o     (desc_err_o),
    .len_err_o      (len_err_o),
    .err_state_o    (err_state_o)
  );
endmodule

// File: tb/sim_sg_desc_walker.sv
`timescale 1ns/1ps
module sim_sg_desc_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] start_addr_i;
  logic [23:0] expect_bytes_i;
  logic        rd_req_valid_o, rd_req_ready_i;
  logic [31:0] rd_req_addr_o;
  logic        rd_rsp_valid_i, rd_rsp_ready_o;
  logic [63:0] rd_rsp_data_i;
  logic        mv_valid_o, mv_ready_i;
  logic [31:0] mv_addr_o;
  logic [15:0] mv_len_o;
  logic        mv_done_i;
  logic        busy_o, done_o, irq_o, desc_err_o, len_err_o;
  logic [1:0]  err_state_o;

  always #2.5 clk = ~clk;

  sg_desc_walker #(.TOT_W(24)) u0 (.*);

  logic [63:0] mem [64];
  logic [31:0] got_addr [32];
  logic [15:0] got_len  [32];
  int got_n, irq_cnt, done_cnt, rd_cnt;
  logic [31:0] exp_addr [32];
  logic [15:0] exp_len  [32];
  int exp_n, exp_irq, exp_rd;
  logic exp_done, exp_derr, exp_lerr;
  logic [1:0] exp_code;
  logic [23:0] ref_total;
  int nchk = 0, nfail = 0;
  logic finished = 1'b0;

  function automatic logic [63:0] dsc(input logic [31:0] a, input logic [15:0] l,
                                      input logic [1:0] act, input logic intr,
                                      input logic last, input logic vld);
    return {a, l, 10'b0, act, 1'b0, intr, last, vld};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // memory model
  initial begin
    logic fire, rfire, pend;
    logic [31:0] sa, pa;
    int dly;
    rd_req_ready_i = 0; rd_rsp_valid_i = 0; rd_rsp_data_i = '0; pend = 0; dly = 0; pa = 0;
    forever begin
      @(negedge clk);
      fire  = rd_req_valid_o && rd_req_ready_i;
      rfire = rd_rsp_valid_i && rd_rsp_ready_o;
      sa    = rd_req_addr_o;
      @(posedge clk); #1;
      if (rfire) rd_rsp_valid_i = 0;
      if (fire) begin pend = 1; dly = $urandom % 3; pa = sa; rd_cnt++; end
      if (pend && !rd_rsp_valid_i) begin
        if (dly == 0) begin
          rd_rsp_valid_i = 1; rd_rsp_data_i = mem[pa[8:3]]; pend = 0;
        end else dly--;
      end
      rd_req_ready_i = ($urandom % 4) != 0;
    end
  end

  // data mover model
  initial begin
    logic fire, pend;
    int dly;
    mv_ready_i = 0; mv_done_i = 0; pend = 0; dly = 0;
    forever begin
      @(negedge clk);
      fire = mv_valid_o && mv_ready_i;
      if (fire && got_n < 32) begin
        got_addr[got_n] = mv_addr_o; got_len[got_n] = mv_len_o; got_n++;
      end
      @(posedge clk); #1;
      mv_done_i = 0;
      if (fire) begin pend = 1; dly = $urandom % 4; end
      else if (pend) begin
        if (dly == 0) begin mv_done_i = 1; pend = 0; end else dly--;
      end
      mv_ready_i = ($urandom % 3) != 0;
    end
  end

  // pulse monitor
  initial forever begin
    @(negedge clk);
    if (irq_o)  irq_cnt++;
    if (done_o) done_cnt++;
  end

  // reference walk from the requirements
  task automatic ref_walk(input logic [31:0] sa, input logic [23:0] ex);
    logic [31:0] a, ad;
    logic [63:0] d;
    logic [15:0] ln;
    logic [1:0] act;
    a = sa; exp_n = 0; exp_irq = 0; exp_rd = 0; ref_total = 0;
    exp_done = 0; exp_derr = 0; exp_lerr = 0; exp_code = 0;
    for (int s = 0; s < 64; s++) begin
      d = mem[a[8:3]]; exp_rd++;
      act = d[5:4]; ad = d[63:32]; ln = d[31:16];
      if (!d[0] || (|d[15:6]) || d[3]) begin exp_derr = 1; exp_code = 1; break; end
      if (act == 2'b10) begin
        if ((|ad[1:0]) || (|ln[1:0])) begin exp_derr = 1; exp_code = 1; break; end
        if (ln != 0) begin
          exp_addr[exp_n] = ad; exp_len[exp_n] = ln; exp_n++; ref_total += 24'(ln);
        end
      end
      if (act == 2'b11 && !d[1] && (|ad[2:0])) begin exp_derr = 1; exp_code = 2; break; end
      if (d[2]) exp_irq++;
      if (d[1]) begin
        if (ref_total != ex) exp_lerr = 1; else exp_done = 1;
        break;
      end
      a = (act == 2'b11) ? ad : a + 8;
    end
  endtask

  task automatic run_case(input string nm, input logic [31:0] sa, input logic [23:0] ex,
                          input logic poke);
    ref_walk(sa, ex);
    got_n = 0; irq_cnt = 0; done_cnt = 0; rd_cnt = 0;
    @(posedge clk); #1;
    start_i = 1; start_addr_i = sa; expect_bytes_i = ex;
    @(posedge clk); #1;
    start_i = 0;
    if (poke) begin
      repeat (3) @(posedge clk);
      #1 start_i = 1; start_addr_i = 32'h100; expect_bytes_i = 24'h7;
      @(posedge clk); #1 start_i = 0;
    end
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy_o) break;
    end
    repeat (2) @(negedge clk);
    chk({nm, " R3 command count"}, 64'(got_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk({nm, " R3 command address"}, 64'(got_addr[i]), 64'(exp_addr[i]));
      chk({nm, " R3 command length"},  64'(got_len[i]),  64'(exp_len[i]));
    end
    chk({nm, " R6 irq pulses"},    64'(irq_cnt),  64'(exp_irq));
    chk({nm, " R5 done pulses"},   64'(done_cnt), 64'(exp_done));
    chk({nm, " R1 R7 desc_err"},   64'(desc_err_o), 64'(exp_derr));
    chk({nm, " R8 len_err"},       64'(len_err_o),  64'(exp_lerr));
    chk({nm, " R4 phase code"},    64'(err_state_o), 64'(exp_code));
    chk({nm, " R9 reads issued"},  64'(rd_cnt),   64'(exp_rd));
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = '0;
  endtask

  task automatic random_chain();
    int idx, nent, t;
    logic [31:0] sa;
    logic [23:0] ex;
    clear_mem();
    idx = $urandom % 4; sa = 32'(idx * 8); nent = 1 + ($urandom % 6);
    for (int k = 0; k < nent; k++) begin
      logic last, it;
      int nxt;
      last = (k == nent - 1); it = $urandom % 2; nxt = idx + 1;
      t = $urandom % 9;
      if (t == 0)      mem[idx] = dsc($urandom, 16'h0, 2'b00, it, last, 1);
      else if (t == 1) mem[idx] = dsc($urandom, 16'h0, 2'b01, it, last, 1);
      else if (t == 6 && !last) begin
        nxt = idx + 1 + ($urandom % 3);
        mem[idx] = dsc(32'(nxt * 8), 16'h0, 2'b11, it, 1'b0, 1);
      end else if (t == 7)
        mem[idx] = dsc(32'h4000, 16'(4 * ($urandom % 8) + 2), 2'b10, it, last, 1);
      else
        mem[idx] = dsc($urandom & 32'hFFFF_FFFC, 16'(4 * ($urandom % 64)), 2'b10, it, last, 1);
      idx = nxt;
    end
    ref_walk(sa, 24'h0);
    ex = ($urandom % 2) ? ref_total : ref_total + 24'd4;
    run_case("random", sa, ex, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    got_n = 0; irq_cnt = 0; done_cnt = 0; rd_cnt = 0;
    rst_n = 0; start_i = 0; start_addr_i = 0; expect_bytes_i = 0;
    clear_mem();
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R10 reset busy",     64'(busy_o), 0);
    chk("R10 reset rd valid", 64'(rd_req_valid_o), 0);
    chk("R10 reset mv valid", 64'(mv_valid_o), 0);
    chk("R10 reset flags",    64'({done_o, irq_o, desc_err_o, len_err_o, err_state_o}), 0);

    // two transfers, start poked while busy (R10)
    clear_mem();
    mem[0] = dsc(32'h1000, 16'h40, 2'b10, 0, 0, 1);
    mem[1] = dsc(32'h2004, 16'h10, 2'b10, 1, 1, 1);
    run_case("R10 busy start", 0, 24'h50, 1'b1);
    // nop, skip, link, transfer (R2 R4)
    clear_mem();
    mem[8]  = dsc(32'hDEAD_BEEF, 16'h3, 2'b00, 1, 0, 1);
    mem[9]  = dsc(32'h1, 16'h1, 2'b01, 0, 0, 1);
    mem[10] = dsc(32'h80, 16'h0, 2'b11, 1, 0, 1);
    mem[16] = dsc(32'h3000, 16'h8, 2'b10, 1, 1, 1);
    run_case("R2 R4 nop skip link", 32'h40, 24'h8, 1'b0);
    // invalid entry mid chain (R1)
    clear_mem();
    mem[0] = dsc(32'h1000, 16'h20, 2'b10, 1, 0, 1);
    run_case("R1 invalid", 0, 24'h20, 1'b0);
    // reserved bit set (R1)
    clear_mem();
    mem[0] = dsc(32'h1000, 16'h20, 2'b10, 0, 1, 1) | 64'h8;
    run_case("R1 reserved bit", 0, 24'h20, 1'b0);
    // misaligned length (R7)
    clear_mem();
    mem[0] = dsc(32'h1000, 16'h6, 2'b10, 1, 1, 1);
    run_case("R7 misaligned len", 0, 24'h6, 1'b0);
    // misaligned address (R7)
    clear_mem();
    mem[0] = dsc(32'h1001, 16'h8, 2'b10, 0, 1, 1);
    run_case("R7 misaligned addr", 0, 24'h8, 1'b0);
    // misaligned link (R4)
    clear_mem();
    mem[0] = dsc(32'h44, 16'h0, 2'b11, 1, 0, 1);
    run_case("R4 bad link", 0, 24'h0, 1'b0);
    // byte total mismatch (R8)
    clear_mem();
    mem[0] = dsc(32'h1000, 16'h40, 2'b10, 0, 0, 1);
    mem[1] = dsc(32'h2004, 16'h10, 2'b10, 1, 1, 1);
    run_case("R8 mismatch", 0, 24'h54, 1'b0);
    // zero-length transfer (R3)
    clear_mem();
    mem[0] = dsc(32'h1000, 16'h0, 2'b10, 0, 1, 1);
    run_case("R3 zero length", 0, 24'h0, 1'b0);
    // end flag on link entry (R5)
    clear_mem();
    mem[0] = dsc(32'h5000, 16'h4, 2'b10, 0, 0, 1);
    mem[1] = dsc(32'h84, 16'h0, 2'b11, 1, 1, 1);
    run_case("R5 end on link", 0, 24'h4, 1'b0);

    for (int r = 0; r < 25; r++) random_chain();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule